// File: doc/BRIEF.md
# Reset Filter and Wake-up Sequencer

This block turns two reset sources into one synchronous internal reset for a network controller core. The first source is an asynchronous, active-low reset pin. It passes through a flip-flop synchronizer and a clock-counted glitch filter, so a low level is accepted as a reset only when it lasts long enough. The second source is a software reset bit. The block captures this bit from configuration register writes, and the reset lasts for as long as the bit stays at one.

After any reset the core sleeps. The transmitter gate is closed and no RAM traffic is issued. The host wakes the core by writing a nonzero node identifier. The block then runs a fixed two-cycle self-check into the packet RAM: a signature byte goes to address 0, and the identifier goes to address 1. A single-cycle completion pulse follows, and the core is then awake. The RAM and the register file sit outside this block.

The sequencer has five states:

- `WS_SLEEP`: post-reset idle.
- `WS_SIG`: writes the signature.
- `WS_ID`: writes the identifier.
- `WS_DONE`: completion pulse, first awake cycle.
- `WS_AWAKE`: steady awake state.

It has four transitions:

- `WS_SLEEP` goes to `WS_SIG` on a nonzero identifier write.
- `WS_SIG` goes to `WS_ID` unconditionally.
- `WS_ID` goes to `WS_DONE` unconditionally.
- `WS_DONE` goes to `WS_AWAKE` unconditionally.

Internal reset takes every state to `WS_SLEEP`, and that transition has priority over all the others.

Top module: `rstwake_top`

## Requirements
- R1: A low level on `rst_pin_n` is recognised as a hardware reset only once the synchronised pin has been low on FILT_LEN (default 5) consecutive clock edges. Any shorter low pulse leaves `int_rst` at 0. For a pulse of sufficient length, `int_rst` rises on the 8th rising edge after the pin falls. It falls on the 4th rising edge after the pin returns high.
- R2: A configuration write (`cfg_wr`=1) with bit 7 of `cfg_wdata` set arms the software reset. `int_rst` goes high one cycle after the arming write and stays high until a later configuration write with bit 7 clear. A configuration write with bit 7 clear never causes a reset.
- R3: An accepted hardware reset clears the software reset bit. When the pin is released, `int_rst` falls with no further configuration write.
- R4: While `int_rst` is 1, `tx_gate` is 0 in that same cycle. On the next cycle the sequencer is in `WS_SLEEP`, with `core_awake`, `ram_we`, `seq_busy` and `seq_done` all at 0.
- R5: A write of a nonzero `nid_wdata` with `nid_wr`=1, made in `WS_SLEEP` outside reset, starts two RAM write cycles beginning on the next cycle. The first has `ram_addr`=0 and `ram_wdata`=0xD1. The second has `ram_addr`=1 and `ram_wdata` equal to the identifier written. `seq_busy` is 1 in exactly these two cycles.
- R6: An identifier write of zero in `WS_SLEEP` leaves the core asleep and produces no RAM write.
- R7: In the cycle after the second RAM write, `seq_done` is 1 for exactly one cycle. From that cycle on, `core_awake` and `tx_gate` stay at 1 until the next reset.
- R8: Identifier writes made during reset, during the two-write sequence, or once awake are ignored: no RAM write starts and the stored identifier does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin, unfiltered |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | DATA_W | Configuration write data; bit SW_BIT is the software reset |
| nid_wr | input | 1 | Node identifier register write strobe |
| nid_wdata | input | DATA_W | Node identifier write data |
| int_rst | output | 1 | Combined internal reset, active high, synchronous |
| core_awake | output | 1 | Core has completed wake-up |
| tx_gate | output | 1 | Transmitter enable, low in any reset |
| ram_addr | output | ADDR_W | Packet RAM write address |
| ram_wdata | output | DATA_W | Packet RAM write data |
| ram_we | output | 1 | Packet RAM write enable |
| seq_busy | output | 1 | Self-check write sequence in progress |
| seq_done | output | 1 | One-cycle pulse when the self-check completes |

## Verification
The assertions assume that `cfg_wr`, `cfg_wdata`, `nid_wr` and `nid_wdata` are synchronous to `clk`, and that the reset pin is either held long enough to be accepted or is a clean glitch. They also assume that the free-running filter and synchronizer have been flushed by one accepted pin reset before any wake-up property is meaningful. The stimulus honours these assumptions in several ways:

- It drives every input on the falling clock edge.
- It opens with a pin reset well beyond the filter length, and compares nothing until that reset has settled.
- It moves the pin only in whole clock periods, so the glitch lengths of 1, 3 and 4 cycles and the accepted lengths of exactly 5 and 6 cycles fall on clean edges.

// File: rtl/rstwake_pkg.sv
package rstwake_pkg;

    typedef enum logic [2:0] {
        WS_SLEEP = 3'd0,
        WS_SIG   = 3'd1,
        WS_ID    = 3'd2,
        WS_DONE  = 3'd3,
        WS_AWAKE = 3'd4
    } wake_state_e;

    function automatic logic is_writing(input wake_state_e s);
        return (s == WS_SIG) || (s == WS_ID);
    endfunction

    function automatic logic is_up(input wake_state_e s);
        return (s == WS_DONE) || (s == WS_AWAKE);
    endfunction

endpackage

// File: rtl/rstwake_pin_filter.sv
module rstwake_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 5
) (
    input  logic clk,
    input  logic pin_n,
    output logic hw_hold
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] CMAX = CW'(FILT_LEN);

    logic [SYNC_STAGES-1:0] chain;
    logic                   pin_sync;
    logic [CW-1:0]          low_cnt;

    // Synchronizer: stage 0 samples the raw pin, later stages follow.
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) chain[0] <= pin_n;
            end else begin : g_next
                always_ff @(posedge clk) chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign pin_sync = chain[SYNC_STAGES-1];

    // Counts consecutive low samples, saturates at the filter length,
    // restarts as soon as the synchronised pin is high.
    always_ff @(posedge clk) begin
        if (pin_sync)
            low_cnt <= '0;
        else if (low_cnt != CMAX)
            low_cnt <= low_cnt + 1'b1;
    end

    assign hw_hold = (low_cnt == CMAX);

    // A high synchronised sample always cancels the hold on the next cycle.
    assert_glitch_reject_R1: assert property (@(posedge clk)
        pin_sync |=> !hw_hold);

endmodule

// File: rtl/rstwake_rst_merge.sv
module rstwake_rst_merge #(
    parameter int DATA_W = 8,
    parameter int SW_BIT = 7
) (
    input  logic              clk,
    input  logic              hw_hold,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              int_rst
);
    logic sw_q;

    // The software bit survives its own reset; only a pin reset clears it.
    always_ff @(posedge clk) begin
        if (hw_hold)
            sw_q <= 1'b0;
        else if (cfg_wr)
            sw_q <= cfg_wdata[SW_BIT];
    end

    always_ff @(posedge clk) int_rst <= hw_hold | sw_q;

    assert_sw_holds_R2: assert property (@(posedge clk)
        sw_q |=> int_rst);

    assert_hw_clears_sw_R3: assert property (@(posedge clk)
        hw_hold |=> (!sw_q && int_rst));

endmodule

// File: rtl/rstwake_seq.sv
module rstwake_seq
    import rstwake_pkg::*;
#(
    parameter int              ADDR_W = 11,
    parameter int              DATA_W = 8,
    parameter logic [DATA_W-1:0] SIG  = DATA_W'(8'hD1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nid_wr,
    input  logic [DATA_W-1:0] nid_wdata,
    output logic              core_awake,
    output logic              tx_gate,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              seq_busy,
    output logic              seq_done
);
    localparam logic [ADDR_W-1:0] SIG_ADDR = '0;
    localparam logic [ADDR_W-1:0] ID_ADDR  = ADDR_W'(1);

    wake_state_e       state, state_nx;
    logic [DATA_W-1:0] id_q;
    logic              wake_req;

    assign wake_req = nid_wr && (nid_wdata != '0);

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            WS_SLEEP: if (wake_req) state_nx = WS_SIG;
            WS_SIG:   state_nx = WS_ID;
            WS_ID:    state_nx = WS_DONE;
            WS_DONE:  state_nx = WS_AWAKE;
            WS_AWAKE: state_nx = WS_AWAKE;
            default:  state_nx = WS_SLEEP;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst)
            state <= WS_SLEEP;
        else
            state <= state_nx;
    end

    // The identifier is latched only at the moment of wake-up.
    always_ff @(posedge clk) begin
        if (rst)
            id_q <= '0;
        else if (state == WS_SLEEP && wake_req)
            id_q <= nid_wdata;
    end

    // Output decode.
    always_comb begin
        ram_we     = 1'b0;
        ram_addr   = SIG_ADDR;
        ram_wdata  = '0;
        seq_busy   = 1'b0;
        seq_done   = 1'b0;
        core_awake = 1'b0;
        unique case (state)
            WS_SLEEP: ;
            WS_SIG: begin
                ram_we    = 1'b1;
                ram_addr  = SIG_ADDR;
                ram_wdata = SIG;
                seq_busy  = 1'b1;
            end
            WS_ID: begin
                ram_we    = 1'b1;
                ram_addr  = ID_ADDR;
                ram_wdata = id_q;
                seq_busy  = 1'b1;
            end
            WS_DONE: begin
                seq_done   = 1'b1;
                core_awake = 1'b1;
            end
            WS_AWAKE: core_awake = 1'b1;
            default: ;
        endcase
        tx_gate = core_awake && !rst;
    end

    assert_rst_sleeps_R4: assert property (@(posedge clk)
        rst |=> (state == WS_SLEEP && !ram_we && !core_awake));

    assert_zero_id_sleeps_R6: assert property (@(posedge clk) disable iff (rst)
        (state == WS_SLEEP && nid_wr && nid_wdata == '0) |=> state == WS_SLEEP);

    assert_second_write_R5: assert property (@(posedge clk) disable iff (rst)
        (ram_we && ram_addr == SIG_ADDR) |=>
            (ram_we && ram_addr == ID_ADDR && ram_wdata == id_q));

    assert_done_after_id_R7: assert property (@(posedge clk) disable iff (rst)
        (ram_we && ram_addr == ID_ADDR) |=> (seq_done && core_awake));

    assert_id_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (state != WS_SLEEP) |=> $stable(id_q));

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({seq_busy, seq_done}));

endmodule

// File: rtl/rstwake_top.sv
module rstwake_top #(
    parameter int                ADDR_W      = 11,
    parameter int                DATA_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter int                FILT_LEN    = 5,
    parameter int                SW_BIT      = 7,
    parameter logic [DATA_W-1:0] SIG         = DATA_W'(8'hD1)
) (
    input  logic              clk,
    input  logic              rst_pin_n,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              nid_wr,
    input  logic [DATA_W-1:0] nid_wdata,
    output logic              int_rst,
    output logic              core_awake,
    output logic              tx_gate,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              seq_busy,
    output logic              seq_done
);
    logic hw_hold;

    rstwake_pin_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) u_filt (
        .clk    (clk),
        .pin_n  (rst_pin_n),
        .hw_hold(hw_hold)
    );

    rstwake_rst_merge #(
        .DATA_W(DATA_W),
        .SW_BIT(SW_BIT)
    ) u_merge (
        .clk      (clk),
        .hw_hold  (hw_hold),
        .cfg_wr   (cfg_wr),
        .cfg_wdata(cfg_wdata),
        .int_rst  (int_rst)
    );

    rstwake_seq #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .SIG   (SIG)
    ) u_seq (
        .clk       (clk),
        .rst       (int_rst),
        .nid_wr    (nid_wr),
        .nid_wdata (nid_wdata),
        .core_awake(core_awake),
        .tx_gate   (tx_gate),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_we    (ram_we),
        .seq_busy  (seq_busy),
        .seq_done  (seq_done)
    );

    assert_tx_closed_R4: assert property (@(posedge clk)
        int_rst |-> !tx_gate);

endmodule

// File: tb/rstwake_top_test.sv
module rstwake_top_test;
    logic       clk = 1'b0;
    logic       rst_pin_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       nid_wr = 1'b0;
    logic [7:0] nid_wdata = 8'h00;
    logic        int_rst, core_awake, tx_gate, ram_we, seq_busy, seq_done;
    logic [10:0] ram_addr;
    logic [7:0]  ram_wdata;

    rstwake_top uut (
        .clk(clk), .rst_pin_n(rst_pin_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .nid_wr(nid_wr), .nid_wdata(nid_wdata), .int_rst(int_rst),
        .core_awake(core_awake), .tx_gate(tx_gate), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_we(ram_we), .seq_busy(seq_busy),
        .seq_done(seq_done)
    );

    always #10 clk = ~clk;

    // Reference model state.
    int  m_p1 = 1, m_p2 = 1, m_cnt = 0, m_sw = 0, m_rst = 0, m_st = 0, m_id = 0;
    int  vectors = 0, errors = 0, cycles = 0;
    bit  cmp_on = 0;
    string tag = "R1";

    always @(posedge clk) begin
        int n_cnt, n_sw, n_rst, n_st, n_id;
        bit hold;
        cycles++;
        hold  = (m_cnt >= 5);
        n_cnt = (m_p2 != 0) ? 0 : ((m_cnt >= 5) ? 5 : m_cnt + 1);
        n_sw  = hold ? 0 : (cfg_wr ? int'(cfg_wdata[7]) : m_sw);
        n_rst = (hold || m_sw != 0) ? 1 : 0;
        n_id  = m_id;
        n_st  = m_st;
        if (m_rst != 0) begin
            n_st = 0; n_id = 0;
        end else if (m_st == 0) begin
            if (nid_wr && nid_wdata != 8'h00) begin
                n_st = 1; n_id = int'(nid_wdata);
            end
        end else if (m_st < 4) n_st = m_st + 1;
        m_p2 = m_p1; m_p1 = int'(rst_pin_n);
        m_cnt = n_cnt; m_sw = n_sw; m_rst = n_rst; m_st = n_st; m_id = n_id;
    end

    task automatic cmp(string sig, int got, int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h at cycle %0d",
                     tag, sig, got, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            int e_we, e_aw;
            e_we = (m_st == 1 || m_st == 2) ? 1 : 0;
            e_aw = (m_st >= 3) ? 1 : 0;
            cmp("int_rst", int'(int_rst), m_rst);
            cmp("ram_we", int'(ram_we), e_we);
            cmp("seq_busy", int'(seq_busy), e_we);
            cmp("seq_done", int'(seq_done), (m_st == 3) ? 1 : 0);
            cmp("core_awake", int'(core_awake), e_aw);
            cmp("tx_gate", int'(tx_gate), (e_aw != 0 && m_rst == 0) ? 1 : 0);
            if (e_we != 0) begin
                cmp("ram_addr", int'(ram_addr), (m_st == 2) ? 1 : 0);
                cmp("ram_wdata", int'(ram_wdata), (m_st == 1) ? 8'hD1 : m_id);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_pulse(int len);
        @(negedge clk) rst_pin_n = 1'b0;
        idle(len);
        rst_pin_n = 1'b1;
        idle(12);
    endtask

    task automatic nid(logic [7:0] v);
        @(negedge clk) begin nid_wr = 1'b1; nid_wdata = v; end
        @(negedge clk) nid_wr = 1'b0;
    endtask

    task automatic cfg(logic [7:0] v);
        @(negedge clk) begin cfg_wr = 1'b1; cfg_wdata = v; end
        @(negedge clk) cfg_wr = 1'b0;
    endtask

    initial begin
        // Watchdog.
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R1 power-up: long pin reset flushes synchronizer and filter.
        idle(12);
        cmp_on = 1;
        idle(2);
        tag = "R4"; cmp("reset state int_rst", int'(int_rst), 1);
        rst_pin_n = 1'b1;
        idle(10);
        // R1 glitches of 1, 3 and 4 cycles, then exact 5 and 6 cycles.
        tag = "R1";
        pin_pulse(1); pin_pulse(3); pin_pulse(4);
        pin_pulse(5); pin_pulse(6);
        // R6 zero identifier.
        tag = "R6"; nid(8'h00); idle(6);
        // R5 / R7 wake-up with 0x5A.
        tag = "R5"; nid(8'h5A); idle(3);
        tag = "R7"; idle(4);
        // R8 writes once awake and during the sequence.
        tag = "R8"; nid(8'h77); idle(4);
        // R2 software reset, and bit 7 clear writes.
        tag = "R2"; cfg(8'h7F); idle(3);
        cfg(8'h80); idle(6);
        tag = "R8"; nid(8'h42); idle(2);
        tag = "R2"; cfg(8'h00); idle(6);
        tag = "R8"; nid(8'h33); nid(8'h99); idle(6);
        // R3 hardware reset clears an armed software bit.
        tag = "R3"; cfg(8'hFF); idle(4);
        pin_pulse(6);
        idle(4);
        tag = "R5"; nid(8'hFF); idle(8);
        // R4 pin reset in the middle of a sequence.
        tag = "R4"; cfg(8'h80); cfg(8'h00); idle(5);
        nid(8'h01);
        @(negedge clk) rst_pin_n = 1'b0;
        idle(7); rst_pin_n = 1'b1; idle(12);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule